// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervisory timer that software must service inside a time window. A 12-bit down-counter steps once for each pulse on a slow enable input, typically 256 Hz. At the default full-scale load of 0xFFF, a timeout takes about sixteen seconds. Software restarts the counter by writing a keyed command. The restart is accepted only once the count has fallen to or below a programmed window threshold. An early restart counts as a fault, and so does letting the count run out.

The timing and routing configuration sits in a mode register that accepts a single write after reset. Once that write has been made, software cannot change or stop the timer until the next reset. A fault sets a sticky status flag. Depending on the mode, the fault also drives a level interrupt and a one-cycle reset request. The reset request goes either to the whole system or to the processor alone. Two halt inputs freeze counting during idle or debug states, and each is enabled by its own mode bit.

All registers sit on a small synchronous bus. A write takes effect on the clock edge where it is presented. Read data is combinational from the address.

Top module: `guard_timer`

## Requirements
- R1: After reset the mode register reads 0x3FFF2FFF, the counter holds 0xFFF, the status flags are clear, and faultIrq, sysRstReq and cpuRstReq are low.
- R2: The mode register (byte address 0x4) accepts exactly one write after reset. That write loads the counter at once from the new reload field, bits 11:0. Every later mode write changes neither the register nor the counter.
- R3: Each tickEn pulse decrements the counter by one, unless the counter is disabled or halted.
- R4: A write to the control register (address 0x0) is a restart only if bits 31:24 hold 0xA5 and bit 0 is 1. Any other control write has no effect.
- R5: A restart with the count at or below the window field (mode bits 27:16) is valid. The counter reloads on the next tick. If a tick arrives in the same cycle as the restart, the reload happens on that tick and no underflow is raised.
- R6: A restart while the count is above the window field sets the window-error flag (status bit 1) and leaves the count unchanged.
- R7: A tick that finds the count at zero, with no restart pending, sets the underflow flag (status bit 0) and reloads the counter.
- R8: The status register (address 0x8) shows the live count in bits 27:16, the window-error flag in bit 1 and the underflow flag in bit 0. A status read clears both flags.
- R9: faultIrq is high whenever mode bit 12 is set and either status flag is set.
- R10: A fault with mode bit 13 set produces a one-cycle pulse in the cycle after the fault. The pulse goes to cpuRstReq if mode bit 14 is set and to sysRstReq otherwise.
- R11: Ticks are ignored while idleIn is high and mode bit 29 is set, and while debugIn is high and mode bit 28 is set. With these bits clear, the inputs have no effect.
- R12: With mode bit 15 set, the counter never moves on a tick and restart commands are ignored without any fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and logic clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Slow count enable, one clock wide per tick |
| idleIn | input | 1 | System idle indication |
| debugIn | input | 1 | Debugger halt indication |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address: 0x0 control, 0x4 mode, 0x8 status |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed register |
| faultIrq | output | 1 | Level fault interrupt |
| sysRstReq | output | 1 | One-cycle system reset request |
| cpuRstReq | output | 1 | One-cycle processor-only reset request |

## Verification
Two events can fall in the same cycle: a restart command and a counter tick. This matters most when the count is already zero, because the tick alone would underflow. The bench runs the counter down to zero and then presents the keyed restart write with tickEn high in that one cycle. It judges the result through the status register and the reset pins. The count must come back at the reload value, the underflow flag must stay clear, and no reset pulse may appear. A second case uses the same window test from the other side: restarts issued above the threshold must raise a window error and leave the count alone.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int CNT_W   = 12;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 4;
  localparam logic [7:0] RESTART_KEY = 8'hA5;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = 4'h0;
  localparam logic [ADDR_W-1:0] MODE_ADDR = 4'h4;
  localparam logic [ADDR_W-1:0] STAT_ADDR = 4'h8;

  localparam int WIN_LSB    = 16;
  localparam int IRQEN_BIT  = 12;
  localparam int RSTEN_BIT  = 13;
  localparam int CPUONLY_BIT = 14;
  localparam int DIS_BIT    = 15;
  localparam int DBGHLT_BIT = 28;
  localparam int IDLHLT_BIT = 29;

  localparam logic [DATA_W-1:0] MODE_RESET = 32'h3FFF_2FFF;

  typedef struct packed {
    logic tick;
    logic restart;
    logic load;
  } dpStrobe_t;
endpackage

// File: rtl/gtm_datapath.sv
module gtm_datapath
  import gtm_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strb,
  input  logic [CW-1:0] reloadVal,
  input  logic [CW-1:0] windowVal,
  output logic [CW-1:0] cnt,
  output logic          ufEv,
  output logic          winEv
);
  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

  logic pending;
  logic validRst;
  logic reloadNow;

  assign validRst  = strb.restart && (cnt <= windowVal);
  assign winEv     = strb.restart && (cnt > windowVal) && !strb.load;
  assign reloadNow = pending || validRst;
  assign ufEv      = strb.tick && !strb.load && !reloadNow && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= CNT_MAX;
      pending <= 1'b0;
    end else if (strb.load) begin
      cnt     <= reloadVal;
      pending <= 1'b0;
    end else if (strb.tick) begin
      pending <= 1'b0;
      if (reloadNow || cnt == '0) cnt <= reloadVal;
      else                        cnt <= cnt - 1'b1;
    end else if (validRst) begin
      pending <= 1'b1;
    end
  end

  // R3
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.load) |=> $stable(cnt));

  // R7
  uf_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    ufEv |=> (cnt == $past(reloadVal)));

  // R6
  win_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (winEv && !strb.tick) |=> $stable(cnt));
endmodule

// File: rtl/gtm_ctrl.sv
module gtm_ctrl
  import gtm_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          tickEn,
  input  logic          idleIn,
  input  logic          debugIn,
  input  logic          busSel,
  input  logic          busWrite,
  input  logic [AW-1:0] busAddr,
  input  logic [DW-1:0] busWdata,
  output logic [DW-1:0] busRdata,
  input  logic [CW-1:0] cnt,
  input  logic          ufEv,
  input  logic          winEv,
  output dpStrobe_t     strb,
  output logic [CW-1:0] reloadVal,
  output logic [CW-1:0] windowVal,
  output logic          faultIrq,
  output logic          sysRstReq,
  output logic          cpuRstReq
);
  localparam int PAD_W = DW - WIN_LSB - CW;

  logic [DW-1:0] modeReg;
  logic          locked;
  logic          ufFlag, winFlag;
  logic          wrMode, wrCtrl, rdStat, wrModeOk;
  logic          halted, fault;

  assign wrMode   = busSel && busWrite && (busAddr == MODE_ADDR);
  assign wrCtrl   = busSel && busWrite && (busAddr == CTRL_ADDR);
  assign rdStat   = busSel && !busWrite && (busAddr == STAT_ADDR);
  assign wrModeOk = wrMode && !locked;

  assign halted = (modeReg[IDLHLT_BIT] && idleIn) || (modeReg[DBGHLT_BIT] && debugIn);

  always_comb begin
    strb.load    = wrModeOk;
    strb.tick    = tickEn && !halted && !modeReg[DIS_BIT];
    strb.restart = wrCtrl && !modeReg[DIS_BIT]
                   && (busWdata[DW-1 -: 8] == RESTART_KEY) && busWdata[0];
  end

  assign reloadVal = wrModeOk ? busWdata[CW-1:0] : modeReg[CW-1:0];
  assign windowVal = modeReg[WIN_LSB +: CW];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_RESET;
      locked  <= 1'b0;
    end else if (wrModeOk) begin
      modeReg <= busWdata;
      locked  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ufFlag  <= 1'b0;
      winFlag <= 1'b0;
    end else begin
      if (ufEv)        ufFlag <= 1'b1;
      else if (rdStat) ufFlag <= 1'b0;
      if (winEv)        winFlag <= 1'b1;
      else if (rdStat)  winFlag <= 1'b0;
    end
  end

  assign fault = ufEv || winEv;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysRstReq <= 1'b0;
      cpuRstReq <= 1'b0;
    end else begin
      sysRstReq <= fault && modeReg[RSTEN_BIT] && !modeReg[CPUONLY_BIT];
      cpuRstReq <= fault && modeReg[RSTEN_BIT] &&  modeReg[CPUONLY_BIT];
    end
  end

  assign faultIrq = modeReg[IRQEN_BIT] && (ufFlag || winFlag);

  always_comb begin
    unique case (busAddr)
      MODE_ADDR: busRdata = modeReg;
      STAT_ADDR: busRdata = {{PAD_W{1'b0}}, cnt, {(WIN_LSB-2){1'b0}}, winFlag, ufFlag};
      default:   busRdata = '0;
    endcase
  end

  // R2
  mode_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(locked) |-> $stable(modeReg));

  // R10
  rst_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysRstReq || cpuRstReq) |-> ($past(fault) && $past(modeReg[RSTEN_BIT])));

  // R10
  rst_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sysRstReq && cpuRstReq));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultIrq) |-> ($past(fault) || $past(wrModeOk)));
endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import gtm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              idleIn,
  input  logic              debugIn,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              faultIrq,
  output logic              sysRstReq,
  output logic              cpuRstReq
);
  dpStrobe_t        strb;
  logic [CNT_W-1:0] cnt, reloadVal, windowVal;
  logic             ufEv, winEv;

  gtm_ctrl #(.CW(CNT_W), .DW(DATA_W), .AW(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .idleIn(idleIn), .debugIn(debugIn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .cnt(cnt), .ufEv(ufEv), .winEv(winEv), .strb(strb),
    .reloadVal(reloadVal), .windowVal(windowVal), .faultIrq(faultIrq),
    .sysRstReq(sysRstReq), .cpuRstReq(cpuRstReq)
  );

  gtm_datapath #(.CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reloadVal(reloadVal),
    .windowVal(windowVal), .cnt(cnt), .ufEv(ufEv), .winEv(winEv)
  );
endmodule

// File: tb/tb_guard_timer.sv
module tb_guard_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickEn = 1'b0, idleIn = 1'b0, debugIn = 1'b0;
  logic        busSel = 1'b0, busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        faultIrq, sysRstReq, cpuRstReq;

  int checks = 0;
  int errors = 0;

  typedef struct { string tag; logic [31:0] val; } expItem_t;
  expItem_t    expQ[$];
  logic [31:0] monData;
  event        rdDone;

  always #5 clk = ~clk;

  guard_timer dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .idleIn(idleIn), .debugIn(debugIn),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .faultIrq(faultIrq), .sysRstReq(sysRstReq), .cpuRstReq(cpuRstReq)
  );

  // scoreboard monitor: compares each read result with the queued expectation
  initial forever begin
    @(rdDone);
    checks++;
    if (expQ.size() == 0) begin
      errors++;
      $display("FAIL scoreboard underrun act=%h exp=none", monData);
    end else begin
      expItem_t it;
      it = expQ.pop_front();
      if (monData !== it.val) begin
        errors++;
        $display("FAIL %s act=%h exp=%h", it.tag, monData, it.val);
      end
    end
  end

  task automatic pinChk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
  endtask

  task automatic busWr(input logic [3:0] a, input logic [31:0] d, input logic tk);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; tickEn = tk;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0; busWdata = '0; tickEn = 1'b0;
  endtask

  task automatic busRd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    expItem_t it;
    it.tag = tag; it.val = exp;
    expQ.push_back(it);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 monData = busRdata;
    -> rdDone;
    @(negedge clk);
    busSel = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  localparam logic [31:0] RESTART = 32'hA500_0001;

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired, all requirements act=hung exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    busRd(4'h4, 32'h3FFF_2FFF, "R1 mode reset value");
    busRd(4'h8, 32'h0FFF_0000, "R1 status reset value");
    pinChk("R1 irq low", faultIrq, 1'b0);
    pinChk("R1 sysRst low", sysRstReq, 1'b0);
    pinChk("R1 cpuRst low", cpuRstReq, 1'b0);

    // R2 write-once mode: reload 10, window 4, irq+rst enabled, halts enabled
    busWr(4'h4, 32'h3004_300A, 1'b0);
    busRd(4'h4, 32'h3004_300A, "R2 mode accepted");
    busRd(4'h8, 32'h000A_0000, "R2 counter loaded");
    busWr(4'h4, 32'h0000_0005, 1'b0);
    busRd(4'h4, 32'h3004_300A, "R2 second write ignored");
    busRd(4'h8, 32'h000A_0000, "R2 second write no reload");

    // R3 decrement
    tick(3);
    busRd(4'h8, 32'h0007_0000, "R3 three ticks");

    // R6 early restart
    busWr(4'h0, RESTART, 1'b0);
    pinChk("R10 sysRst pulse on window error", sysRstReq, 1'b1);
    pinChk("R9 irq on window error", faultIrq, 1'b1);
    @(negedge clk);
    pinChk("R10 sysRst single cycle", sysRstReq, 1'b0);
    busRd(4'h8, 32'h0007_0002, "R6 window error flag, count kept");
    pinChk("R8 irq drops after read clear", faultIrq, 1'b0);
    busRd(4'h8, 32'h0007_0000, "R8 flags cleared by read");

    // R4 wrong key / missing bit
    tick(3);
    busWr(4'h0, 32'h5A00_0001, 1'b0);
    busWr(4'h0, 32'hA500_0000, 1'b0);
    tick(1);
    busRd(4'h8, 32'h0003_0000, "R4 bad restarts ignored");

    // R5 valid restart then reload on next tick
    busWr(4'h0, RESTART, 1'b0);
    busRd(4'h8, 32'h0003_0000, "R5 valid restart no fault");
    tick(1);
    busRd(4'h8, 32'h000A_0000, "R5 reload on next tick");

    // R7 underflow
    tick(10);
    busRd(4'h8, 32'h0000_0000, "R7 count at zero");
    tick(1);
    pinChk("R10 sysRst pulse on underflow", sysRstReq, 1'b1);
    pinChk("R9 irq on underflow", faultIrq, 1'b1);
    busRd(4'h8, 32'h000A_0001, "R7 underflow flag and reload");

    // R5 restart coinciding with a tick at zero
    tick(10);
    busWr(4'h0, RESTART, 1'b1);
    pinChk("R5 no reset pulse on coincident restart", sysRstReq, 1'b0);
    busRd(4'h8, 32'h000A_0000, "R5 coincident restart reloads, no underflow");

    // R11 halts
    idleIn = 1'b1;
    tick(2);
    busRd(4'h8, 32'h000A_0000, "R11 idle halt freezes");
    idleIn = 1'b0; debugIn = 1'b1;
    tick(2);
    busRd(4'h8, 32'h000A_0000, "R11 debug halt freezes");
    debugIn = 1'b0;
    tick(1);
    busRd(4'h8, 32'h0009_0000, "R11 resumes after halt");

    // R12 disabled
    doReset();
    busWr(4'h4, 32'h0000_8005, 1'b0);
    tick(2);
    busRd(4'h8, 32'h0005_0000, "R12 disabled counter holds");
    busWr(4'h0, RESTART, 1'b0);
    busRd(4'h8, 32'h0005_0000, "R12 restart ignored without fault");

    // R10 processor-only routing, R9 irq masked, R11 halt bits clear
    doReset();
    busWr(4'h4, 32'h0002_6008, 1'b0);
    idleIn = 1'b1;
    tick(1);
    idleIn = 1'b0;
    busRd(4'h8, 32'h0007_0000, "R11 idle without halt bit counts");
    busWr(4'h0, RESTART, 1'b0);
    pinChk("R10 cpuRst pulse", cpuRstReq, 1'b1);
    pinChk("R10 sysRst quiet", sysRstReq, 1'b0);
    pinChk("R9 irq masked", faultIrq, 1'b0);
    @(negedge clk);
    pinChk("R10 cpuRst single cycle", cpuRstReq, 1'b0);
    busRd(4'h8, 32'h0007_0002, "R6 window error with cpu routing");

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule